// File: doc/BRIEF.md
# Descriptor Ring Queue Context Registers

This block holds the control context of one descriptor ring, either transmit or receive. Each queue gets its own instance. A host programs the ring through a small word-addressed register window. The base address is written as two plain 32-bit words. Every other field is set by writing an opcode-tagged command word to a single control offset. The same control offset reads back the status bits, and one more offset returns both ring pointers packed into one word.

The stored context drives a set of outputs for the datapath: the 4 KiB-aligned base address, the ring and block size exponents, the entry stride in bytes, the completion queue number, the function ID, both pointers, the enable flag and the active flag. A one-cycle advance strobe from the datapath moves the consumer pointer forward by one entry. The strobe only counts while the queue is enabled.

Host reads are registered. Read data and its valid flag appear one cycle after the request. Writes and advance strobes take effect at the clock edge that samples them.

Top module: `qctx_regfile`

## Requirements
- R1: In the cycle after synchronous reset is released, the queue is disabled, both pointers are zero, the base address is zero and `host_rvalid` is low.
- R2: A write to byte offset 0x00 sets base address bits 31:12 from data bits 31:12, and data bits 11:0 are discarded. A write to 0x04 sets base address bits 63:32. Reading 0x00 returns the low word with bits 11:0 zero, and reading 0x04 returns the high word.
- R3: A control write (offset 0x08) whose bits 31:16 equal 0x8002 sets the ring size exponent from bits 7:0 and the block size exponent from bits 15:8. `q_stride` becomes 16 shifted left by the block exponent, for block exponents from 0 to 27. Reading 0x0C returns the block exponent in bits 15:8 and the ring exponent in bits 7:0.
- R4: A control write whose bits 31:30 are both one sets the completion queue number from the low CQN_W bits of the word. Reading 0x0C returns that number in bits 31:16.
- R5: A control write with bits 31:16 equal to 0x8080 loads the producer pointer from bits 15:0. A control write with bits 31:16 equal to 0x8090 loads the consumer pointer from bits 15:0.
- R6: A control write with bits 31:8 equal to 0x400001 sets the enable flag to bit 0. A control write with bits 31:16 equal to 0x8001 sets the function ID from bits 15:0.
- R7: Reading offset 0x10 returns the producer pointer in bits 15:0 and the consumer pointer in bits 31:16.
- R8: Reading offset 0x08 returns the enable flag in bit 0 and the active flag in bit 3, with all other bits zero. Active is high exactly when the queue is enabled and the two pointers differ, and `q_active` shows the same value.
- R9: Each cycle in which `dp_cons_adv` is high while the queue is enabled increments the consumer pointer by one, modulo 2^16, so 0xFFFF becomes 0x0000.
- R10: `dp_cons_adv` has no effect while the queue is disabled. If a consumer-pointer load command arrives in the same cycle as an advance, the loaded value wins.
- R11: A control write with any other opcode changes no field. Examples are 0x80910005, 0x40000200, 0x00001234 and 0x80030001.
- R12: `host_rvalid` is high exactly one cycle after each cycle with `host_rd` high. Reading an unmapped offset (0x14, 0x18 or 0x1C) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | ADDR_W | Host write byte offset |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_raddr | input | ADDR_W | Host read byte offset |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| dp_cons_adv | input | 1 | Datapath consumer advance strobe |
| q_base | output | 64 | Ring base address, 4 KiB aligned |
| q_ring_log | output | 8 | log2 of ring entries |
| q_blk_log | output | 8 | log2 of descriptors per block |
| q_stride | output | 32 | Entry stride in bytes |
| q_cqn | output | CQN_W | Completion queue number |
| q_func | output | FUNC_W | Function ID |
| q_prod | output | PTR_W | Producer pointer |
| q_cons | output | PTR_W | Consumer pointer |
| q_enable | output | 1 | Queue enable flag |
| q_active | output | 1 | Enabled and pointers differ |

## Verification
The hardest cases are collisions between host commands and the datapath strobe. One is a consumer-pointer load landing in the same cycle as an advance. Another is advances arriving while the queue is disabled. The bench drives the strobe in exactly the cycle chosen for a control write. It also first parks the consumer pointer at 0xFFFF, so the wrap happens on a single strobe. Commands with near-miss opcodes are written after a known context is set up, and the context is then read back whole to show that nothing moved.

// File: rtl/qctx_pkg.sv
package qctx_pkg;

  // word index of each host-visible offset (byte offset >> 2)
  localparam logic [2:0] WIX_BASE_LO = 3'd0;
  localparam logic [2:0] WIX_BASE_HI = 3'd1;
  localparam logic [2:0] WIX_CTRL    = 3'd2;
  localparam logic [2:0] WIX_CFG     = 3'd3;
  localparam logic [2:0] WIX_PTRS    = 3'd4;

  localparam logic [15:0] OP_SIZE = 16'h8002;
  localparam logic [15:0] OP_PROD = 16'h8080;
  localparam logic [15:0] OP_CONS = 16'h8090;
  localparam logic [15:0] OP_FUNC = 16'h8001;
  localparam logic [23:0] OP_EN   = 24'h400001;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_SIZE,
    CK_CQN,
    CK_PROD,
    CK_CONS,
    CK_EN,
    CK_FUNC
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e   kind;
    logic [31:0] arg;
  } qcmd_t;

endpackage

// File: rtl/qctx_cmd_decode.sv
module qctx_cmd_decode
  import qctx_pkg::*;
(
  input  logic        ctrl_wr,
  input  logic [31:0] word,
  output qcmd_t       cmd
);

  always_comb begin
    cmd.arg  = word;
    cmd.kind = CK_NONE;
    if (ctrl_wr) begin
      if (word[31:30] == 2'b11)           cmd.kind = CK_CQN;
      else if (word[31:16] == OP_SIZE)    cmd.kind = CK_SIZE;
      else if (word[31:16] == OP_PROD)    cmd.kind = CK_PROD;
      else if (word[31:16] == OP_CONS)    cmd.kind = CK_CONS;
      else if (word[31:16] == OP_FUNC)    cmd.kind = CK_FUNC;
      else if (word[31:8]  == OP_EN)      cmd.kind = CK_EN;
    end
  end

endmodule

// File: rtl/qctx_state.sv
module qctx_state
  import qctx_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int CQN_W      = 16,
  parameter int FUNC_W     = 16,
  parameter int DESC_BYTES = 16,
  parameter int ALIGN_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_base_lo,
  input  logic              wr_base_hi,
  input  logic              ctrl_wr,
  input  logic [31:0]       wdata,
  input  qcmd_t             cmd,
  input  logic              cons_adv,
  output logic [63:0]       base,
  output logic [7:0]        ring_log,
  output logic [7:0]        blk_log,
  output logic [31:0]       stride,
  output logic [CQN_W-1:0]  cqn,
  output logic [FUNC_W-1:0] func,
  output logic [PTR_W-1:0]  prod,
  output logic [PTR_W-1:0]  cons,
  output logic              enable,
  output logic              active
);

  localparam int HI_ALIGN = 32 - ALIGN_BITS;

  logic [HI_ALIGN-1:0] base_lo_q;
  logic [31:0]         base_hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
    end else begin
      if (wr_base_lo) base_lo_q <= wdata[31:ALIGN_BITS];
      if (wr_base_hi) base_hi_q <= wdata;
    end
  end

  assign base = {base_hi_q, base_lo_q, {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_log <= '0;
      blk_log  <= '0;
      stride   <= 32'(DESC_BYTES);
      cqn      <= '0;
      func     <= '0;
      enable   <= 1'b0;
    end else begin
      case (cmd.kind)
        CK_SIZE: begin
          ring_log <= cmd.arg[7:0];
          blk_log  <= cmd.arg[15:8];
          stride   <= 32'(DESC_BYTES) << cmd.arg[15:8];
        end
        CK_CQN:  cqn    <= cmd.arg[CQN_W-1:0];
        CK_FUNC: func   <= cmd.arg[FUNC_W-1:0];
        CK_EN:   enable <= cmd.arg[0];
        default: ;
      endcase
    end
  end

  // producer pointer: host load only
  always_ff @(posedge clk) begin
    if (rst)                     prod <= '0;
    else if (cmd.kind == CK_PROD) prod <= cmd.arg[PTR_W-1:0];
  end

  // consumer pointer: host load has priority over datapath advance
  always_ff @(posedge clk) begin
    if (rst)                      cons <= '0;
    else if (cmd.kind == CK_CONS) cons <= cmd.arg[PTR_W-1:0];
    else if (cons_adv && enable)  cons <= cons + 1'b1;
  end

  assign active = enable && (prod != cons);

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!enable && prod == '0 && cons == '0));

  a_r9_adv_step: assert property (@(posedge clk) disable iff (rst)
    (cons_adv && enable && cmd.kind != CK_CONS) |=> cons == PTR_W'($past(cons) + 1'b1));

  a_r10_adv_ignored: assert property (@(posedge clk) disable iff (rst)
    (cons_adv && !enable && cmd.kind != CK_CONS) |=> $stable(cons));

  a_r5_prod_load: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[31:16] == OP_PROD) |=> prod == $past(wdata[PTR_W-1:0]));

  a_r11_unknown_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && cmd.kind == CK_NONE && !(cons_adv && enable))
      |=> ($stable(enable) && $stable(prod) && $stable(cons) && $stable(cqn)
           && $stable(func) && $stable(ring_log) && $stable(blk_log)));

endmodule

// File: rtl/qctx_readmux.sv
module qctx_readmux
  import qctx_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int CQN_W  = 16,
  parameter int WIX_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic [WIX_W-1:0] rwix,
  input  logic [63:0]      base,
  input  logic [7:0]       ring_log,
  input  logic [7:0]       blk_log,
  input  logic [CQN_W-1:0] cqn,
  input  logic [PTR_W-1:0] prod,
  input  logic [PTR_W-1:0] cons,
  input  logic             enable,
  input  logic             active,
  output logic [31:0]      rdata,
  output logic             rvalid
);

  logic [31:0] sel;

  always_comb begin
    sel = '0;
    case (rwix)
      WIX_W'(WIX_BASE_LO): sel = base[31:0];
      WIX_W'(WIX_BASE_HI): sel = base[63:32];
      WIX_W'(WIX_CTRL): begin
        sel[0] = enable;
        sel[3] = active;
      end
      WIX_W'(WIX_CFG): begin
        sel[7:0]          = ring_log;
        sel[15:8]         = blk_log;
        sel[16 +: CQN_W]  = cqn;
      end
      WIX_W'(WIX_PTRS): begin
        sel[0 +: PTR_W]   = prod;
        sel[16 +: PTR_W]  = cons;
      end
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= sel;
    end
  end

  a_r12_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);

  a_r12_rvalid_idle: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);

  a_r8_status_bits: assert property (@(posedge clk) disable iff (rst)
    (rd && rwix == WIX_W'(WIX_CTRL)) |=> (rdata[3] == $past(active) && rdata[0] == $past(enable)));

endmodule

// File: rtl/qctx_regfile.sv
module qctx_regfile
  import qctx_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int PTR_W      = 16,
  parameter int CQN_W      = 16,
  parameter int FUNC_W     = 16,
  parameter int DESC_BYTES = 16,
  parameter int ALIGN_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [31:0]       host_wdata,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  input  logic              dp_cons_adv,
  output logic [63:0]       q_base,
  output logic [7:0]        q_ring_log,
  output logic [7:0]        q_blk_log,
  output logic [31:0]       q_stride,
  output logic [CQN_W-1:0]  q_cqn,
  output logic [FUNC_W-1:0] q_func,
  output logic [PTR_W-1:0]  q_prod,
  output logic [PTR_W-1:0]  q_cons,
  output logic              q_enable,
  output logic              q_active
);

  localparam int WIX_W = ADDR_W - 2;

  logic [WIX_W-1:0] wwix, rwix;
  logic             wr_lo, wr_hi, wr_ctrl;
  qcmd_t            cmd;

  assign wwix    = host_waddr[ADDR_W-1:2];
  assign rwix    = host_raddr[ADDR_W-1:2];
  assign wr_lo   = host_wr && (wwix == WIX_W'(WIX_BASE_LO));
  assign wr_hi   = host_wr && (wwix == WIX_W'(WIX_BASE_HI));
  assign wr_ctrl = host_wr && (wwix == WIX_W'(WIX_CTRL));

  qctx_cmd_decode u_dec (
    .ctrl_wr (wr_ctrl),
    .word    (host_wdata),
    .cmd     (cmd)
  );

  qctx_state #(
    .PTR_W(PTR_W), .CQN_W(CQN_W), .FUNC_W(FUNC_W),
    .DESC_BYTES(DESC_BYTES), .ALIGN_BITS(ALIGN_BITS)
  ) u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_base_lo(wr_lo),
    .wr_base_hi(wr_hi),
    .ctrl_wr   (wr_ctrl),
    .wdata     (host_wdata),
    .cmd       (cmd),
    .cons_adv  (dp_cons_adv),
    .base      (q_base),
    .ring_log  (q_ring_log),
    .blk_log   (q_blk_log),
    .stride    (q_stride),
    .cqn       (q_cqn),
    .func      (q_func),
    .prod      (q_prod),
    .cons      (q_cons),
    .enable    (q_enable),
    .active    (q_active)
  );

  qctx_readmux #(
    .PTR_W(PTR_W), .CQN_W(CQN_W), .WIX_W(WIX_W)
  ) u_rmux (
    .clk     (clk),
    .rst     (rst),
    .rd      (host_rd),
    .rwix    (rwix),
    .base    (q_base),
    .ring_log(q_ring_log),
    .blk_log (q_blk_log),
    .cqn     (q_cqn),
    .prod    (q_prod),
    .cons    (q_cons),
    .enable  (q_enable),
    .active  (q_active),
    .rdata   (host_rdata),
    .rvalid  (host_rvalid)
  );

endmodule

// File: tb/test_qctx_regfile.sv
module test_qctx_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [4:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [4:0]  host_raddr = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        dp_cons_adv = 1'b0;
  logic [63:0] q_base;
  logic [7:0]  q_ring_log, q_blk_log;
  logic [31:0] q_stride;
  logic [15:0] q_cqn, q_func, q_prod, q_cons;
  logic        q_enable, q_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  qctx_regfile i_qctx_regfile (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_raddr(host_raddr),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .dp_cons_adv(dp_cons_adv),
    .q_base(q_base), .q_ring_log(q_ring_log), .q_blk_log(q_blk_log),
    .q_stride(q_stride), .q_cqn(q_cqn), .q_func(q_func),
    .q_prod(q_prod), .q_cons(q_cons), .q_enable(q_enable), .q_active(q_active)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at negedge, one cycle, optional advance alongside
  task automatic wr_cyc(input logic [4:0] a, input logic [31:0] d, input logic adv);
    @(negedge clk);
    host_wr = 1'b1; host_waddr = a; host_wdata = d; dp_cons_adv = adv;
    @(negedge clk);
    host_wr = 1'b0; dp_cons_adv = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_cyc(a, d, 1'b0);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    host_rd = 1'b1; host_raddr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata; v = host_rvalid;
  endtask

  task automatic adv(input int n);
    @(negedge clk);
    dp_cons_adv = 1'b1;
    repeat (n) @(negedge clk);
    dp_cons_adv = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 enable", q_enable, 0);
    chk("R1 prod", q_prod, 0);
    chk("R1 cons", q_cons, 0);
    chk("R1 base", q_base, 0);
    chk("R1 rvalid", host_rvalid, 0);
  endtask

  task automatic t_base;
    logic [31:0] d; logic v;
    wr(5'h00, 32'h1234_5ABC);
    wr(5'h04, 32'h0000_00FE);
    chk("R2 base out", q_base, 64'h0000_00FE_1234_5000);
    rd(5'h00, d, v);
    chk("R2 read lo", d, 32'h1234_5000);
    chk("R12 rvalid", v, 1);
    rd(5'h04, d, v);
    chk("R2 read hi", d, 32'h0000_00FE);
  endtask

  task automatic t_size_cqn;
    logic [31:0] d; logic v;
    wr(5'h08, 32'h8002_030A);
    chk("R3 ring log", q_ring_log, 8'h0A);
    chk("R3 blk log", q_blk_log, 8'h03);
    chk("R3 stride", q_stride, 32'd128);
    wr(5'h08, 32'hC000_0025);
    chk("R4 cqn", q_cqn, 16'h25);
    rd(5'h0C, d, v);
    chk("R3 R4 cfg read", d, 32'h0025_030A);
  endtask

  task automatic t_ptrs_enable;
    logic [31:0] d; logic v;
    wr(5'h08, 32'h8080_0010);
    wr(5'h08, 32'h8090_0004);
    chk("R5 prod", q_prod, 16'h0010);
    chk("R5 cons", q_cons, 16'h0004);
    rd(5'h10, d, v);
    chk("R7 ptr word", d, 32'h0004_0010);
    wr(5'h08, 32'h8001_0007);
    chk("R6 func", q_func, 16'h0007);
    chk("R8 inactive when disabled", q_active, 0);
    wr(5'h08, 32'h4000_0101);
    chk("R6 enable", q_enable, 1);
  endtask

  task automatic t_status;
    logic [31:0] d; logic v;
    rd(5'h08, d, v);
    chk("R8 status busy", d, 32'h9);
    chk("R8 active out", q_active, 1);
    wr(5'h08, 32'h8090_0010);
    rd(5'h08, d, v);
    chk("R8 status equal ptrs", d, 32'h1);
    chk("R8 active low", q_active, 0);
  endtask

  task automatic t_advance;
    adv(3);
    chk("R9 three advances", q_cons, 16'h0013);
    wr(5'h08, 32'h8090_FFFF);
    adv(1);
    chk("R9 wrap", q_cons, 16'h0000);
  endtask

  task automatic t_disabled;
    logic [31:0] d; logic v;
    wr(5'h08, 32'h8090_0040);
    wr(5'h08, 32'h4000_0100);
    adv(4);
    chk("R10 adv ignored disabled", q_cons, 16'h0040);
    rd(5'h08, d, v);
    chk("R8 status disabled", d, 32'h0);
    wr(5'h08, 32'h4000_0101);
    wr_cyc(5'h08, 32'h8090_0100, 1'b1);
    chk("R10 load wins over adv", q_cons, 16'h0100);
  endtask

  task automatic t_unknown;
    logic [31:0] d; logic v;
    wr(5'h08, 32'h8091_0005);
    wr(5'h08, 32'h4000_0200);
    wr(5'h08, 32'h0000_1234);
    wr(5'h08, 32'h8003_0001);
    rd(5'h10, d, v);
    chk("R11 ptrs untouched", d, 32'h0100_0010);
    rd(5'h0C, d, v);
    chk("R11 cfg untouched", d, 32'h0025_030A);
    chk("R11 enable untouched", q_enable, 1);
    chk("R11 func untouched", q_func, 16'h0007);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic v;
    rd(5'h14, d, v);
    chk("R12 unmapped zero", d, 0);
    rd(5'h1C, d, v);
    chk("R12 unmapped zero hi", d, 0);
    @(negedge clk);
    chk("R12 rvalid idle", host_rvalid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_base();
    t_size_cqn();
    t_ptrs_enable();
    t_status();
    t_advance();
    t_disabled();
    t_unknown();
    t_unmapped();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule